// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm timer. Software writes a number of seconds into a load register. While counting is enabled, the live counter drops by one on every pulse of a one-second tick input. When the counter steps from one down to zero, the block sets a sticky pending flag and the counter stays at zero. Software clears the flag by writing a one to it.

The pending flag drives two outputs, and each has its own enable bit. One output is an interrupt request. The other is a wakeup request meant for a power controller. The usual way to rearm the alarm is:

1. Turn the counter off.
2. Clear the pending flag.
3. Write zero to the load register.
4. Wait briefly.
5. Write the new count and turn the counter back on.

A second register group, for a weekly alarm, is decoded so that software can disable it and clear it. The weekly group has no matching logic, so its pending flag never sets.

Access goes through a simple register port. A write takes effect on the rising clock edge when the write strobe is high. Read data is combinational from the address. All offsets are byte addresses.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset, every register reads 0, and both the interrupt output and the wakeup output are low.
- R2: A write to offset 0x20 does two things on that clock edge. It stores the value, which 0x20 then reads back. It also copies the value into the live counter, which reads at offset 0x24.
- R3: Bit 0 of offset 0x28 is the count enable. While it is 1, each cycle with `sec_tick` high decrements a nonzero live count by exactly 1. While it is 0, the live count does not change.
- R4: When the live count steps from 1 to 0, bit 0 of offset 0x30 (pending) becomes 1 on that same edge. The count then holds at 0. Further ticks do not set pending again after software clears it.
- R5: Writing 1 to bit 0 of offset 0x30 clears pending. Writing 0 there has no effect. If an expiry and a clear happen in the same cycle, the flag stays set.
- R6: `alarm_irq` is high exactly when pending is 1 and bit 0 of offset 0x2C (interrupt enable) is 1.
- R7: `alarm_wake` is high exactly when pending is 1 and bit 0 of offset 0x50 (wakeup enable) is 1.
- R8: Loading zero never sets pending. A load during a countdown restarts the count from the new value.
- R9: Bit 0 of offset 0x44 (weekly enable) and bit 0 of offset 0x48 (weekly interrupt enable) are read/write. Bit 0 of offset 0x4C (weekly pending) reads 0 and accepts a write of 1 to clear.
- R10: Writes to offset 0x24 are ignored. Reads of unmapped offsets return 0. Bits above bit 0 of the single-bit registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| alarm_irq | output | 1 | Interrupt request |
| alarm_wake | output | 1 | Wakeup request |

## Verification
A wrong live count shows up at offset 0x24 on the first read after the tick that produced it. It also shows up as a pending flag that is early, late or missing, on the edge where the count should have reached zero. A wrong enable or pending state reaches `alarm_irq` and `alarm_wake` combinationally, in the same cycle the register changes. A collision between a clear and an expiry is exposed by reading offset 0x30 right after that single edge.

// File: rtl/scda_pkg.sv
// Package: shared register offsets for the seconds countdown alarm.
// Assumes byte offsets that fit in eight bits.
package scda_pkg;
    localparam logic [7:0] OFF_LOAD  = 8'h20;
    localparam logic [7:0] OFF_LIVE  = 8'h24;
    localparam logic [7:0] OFF_CEN   = 8'h28;
    localparam logic [7:0] OFF_IEN   = 8'h2C;
    localparam logic [7:0] OFF_PEND  = 8'h30;
    localparam logic [7:0] OFF_WKEN  = 8'h44;
    localparam logic [7:0] OFF_WKIE  = 8'h48;
    localparam logic [7:0] OFF_WKPND = 8'h4C;
    localparam logic [7:0] OFF_WAKE  = 8'h50;
endpackage

// File: rtl/scda_counter.sv
// Module: live seconds counter.
// A load has priority over a tick. The counter decrements only while it is
// enabled and nonzero. It pulses fire on the tick that takes it from 1 to 0.
// Assumes sec_tick is synchronous to clk.
module scda_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_data,
    input  logic             cnt_en,
    input  logic             sec_tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    // Decide whether this cycle takes a decrement step.
    always_comb begin
        step = cnt_en && sec_tick && !load_stb && (cnt_q != '0);
        fire = step && (cnt_q == ONE);
    end

    // Hold, load or decrement the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_stb)
            cnt_q <= load_data;
        else if (step)
            cnt_q <= cnt_q - ONE;
    end
endmodule

// File: rtl/scda_regs.sv
// Module: register decode for the alarm and the weekly group.
// Holds the load value, the enables and the pending flags.
// An expiry wins over a clear that arrives in the same cycle.
// The weekly pending flag has no set source.
module scda_regs
    import scda_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] live_cnt,
    input  logic              fire,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              load_stb,
    output logic              cnt_en,
    output logic              irq_en,
    output logic              wake_en,
    output logic              pending
);
    logic [DATA_W-1:0] load_q;
    logic wk_en, wk_ie, wk_pend;
    logic hit_load, hit_cen, hit_ien, hit_pend, hit_wake;
    logic hit_wken, hit_wkie, hit_wkpnd;

    // Decode write strobes per register.
    always_comb begin
        hit_load  = reg_wen && (reg_addr == ADDR_W'(OFF_LOAD));
        hit_cen   = reg_wen && (reg_addr == ADDR_W'(OFF_CEN));
        hit_ien   = reg_wen && (reg_addr == ADDR_W'(OFF_IEN));
        hit_pend  = reg_wen && (reg_addr == ADDR_W'(OFF_PEND));
        hit_wake  = reg_wen && (reg_addr == ADDR_W'(OFF_WAKE));
        hit_wken  = reg_wen && (reg_addr == ADDR_W'(OFF_WKEN));
        hit_wkie  = reg_wen && (reg_addr == ADDR_W'(OFF_WKIE));
        hit_wkpnd = reg_wen && (reg_addr == ADDR_W'(OFF_WKPND));
        load_stb  = hit_load;
    end

    // Update the control bits and the load register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            cnt_en  <= 1'b0;
            irq_en  <= 1'b0;
            wake_en <= 1'b0;
            wk_en   <= 1'b0;
            wk_ie   <= 1'b0;
        end else begin
            if (hit_load) load_q  <= reg_wdata;
            if (hit_cen)  cnt_en  <= reg_wdata[0];
            if (hit_ien)  irq_en  <= reg_wdata[0];
            if (hit_wake) wake_en <= reg_wdata[0];
            if (hit_wken) wk_en   <= reg_wdata[0];
            if (hit_wkie) wk_ie   <= reg_wdata[0];
        end
    end

    // Sticky pending flags, cleared by writing one; an expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            wk_pend <= 1'b0;
        end else begin
            if (fire)
                pending <= 1'b1;
            else if (hit_pend && reg_wdata[0])
                pending <= 1'b0;
            if (hit_wkpnd && reg_wdata[0])
                wk_pend <= 1'b0;
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_LOAD):  reg_rdata = load_q;
            ADDR_W'(OFF_LIVE):  reg_rdata = live_cnt;
            ADDR_W'(OFF_CEN):   reg_rdata[0] = cnt_en;
            ADDR_W'(OFF_IEN):   reg_rdata[0] = irq_en;
            ADDR_W'(OFF_PEND):  reg_rdata[0] = pending;
            ADDR_W'(OFF_WAKE):  reg_rdata[0] = wake_en;
            ADDR_W'(OFF_WKEN):  reg_rdata[0] = wk_en;
            ADDR_W'(OFF_WKIE):  reg_rdata[0] = wk_ie;
            ADDR_W'(OFF_WKPND): reg_rdata[0] = wk_pend;
            default:            reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/scda_outgate.sv
// Module: gates the pending flag onto the interrupt and wakeup outputs.
// Purely combinational, so both outputs follow register changes at once.
module scda_outgate (
    input  logic pending,
    input  logic irq_en,
    input  logic wake_en,
    output logic alarm_irq,
    output logic alarm_wake
);
    // Apply the separate enable for each output.
    always_comb begin
        alarm_irq  = pending & irq_en;
        alarm_wake = pending & wake_en;
    end
endmodule

// File: rtl/sec_countdown_alarm.sv
// Module: top of the seconds countdown alarm.
// Connects the register decode, the live counter and the output gating.
// Assumes a one-cycle sec_tick pulse and a synchronous active-low reset.
module sec_countdown_alarm #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              alarm_irq,
    output logic              alarm_wake
);
    logic [DATA_W-1:0] cnt_q;
    logic fire, load_stb, cnt_en, irq_en, wake_en, pending;

    scda_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .live_cnt(cnt_q), .fire(fire),
        .reg_rdata(reg_rdata), .load_stb(load_stb), .cnt_en(cnt_en),
        .irq_en(irq_en), .wake_en(wake_en), .pending(pending)
    );

    scda_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_data(reg_wdata),
        .cnt_en(cnt_en), .sec_tick(sec_tick), .cnt_q(cnt_q), .fire(fire)
    );

    scda_outgate u_gate (
        .pending(pending), .irq_en(irq_en), .wake_en(wake_en),
        .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
    );
endmodule

// File: rtl/scda_checker.sv
// Module: property checker for the seconds countdown alarm.
// It is bound to the top module and observes both internal and port signals.
module scda_checker
    import scda_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wen,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] cnt_q,
    input logic              fire,
    input logic              load_stb,
    input logic              cnt_en,
    input logic              irq_en,
    input logic              wake_en,
    input logic              pending,
    input logic              alarm_irq,
    input logic              alarm_wake
);
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> cnt_q == $past(reg_wdata));

    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_stb) |=> $stable(cnt_q));

    a_r4_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_stb) |=> cnt_q == '0);

    a_r4_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (pending && cnt_q == '0));

    a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == ADDR_W'(OFF_PEND) && reg_wdata[0] && !fire) |=> !pending);

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (pending && irq_en));

    a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_wake |-> (pending && wake_en));

    a_r8_zero_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && reg_wdata == '0) |=> !fire);
endmodule

bind sec_countdown_alarm scda_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .cnt_q(cnt_q), .fire(fire), .load_stb(load_stb),
    .cnt_en(cnt_en), .irq_en(irq_en), .wake_en(wake_en), .pending(pending),
    .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
);

// File: tb/sec_countdown_alarm_tb.sv
`timescale 1ns/1ps
module sec_countdown_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        alarm_irq, alarm_wake;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sec_countdown_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
        .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
    );

    // op: 0 write, 1 read check, 2 tick count, 3 output check {wake,irq}
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h28, 32'd1, 8'd3}, '{2'd0, 8'h2C, 32'd1, 8'd6},
        '{2'd0, 8'h20, 32'd3, 8'd2}, '{2'd1, 8'h24, 32'd3, 8'd2},
        '{2'd1, 8'h20, 32'd3, 8'd2}, '{2'd2, 8'h00, 32'd1, 8'd3},
        '{2'd1, 8'h24, 32'd2, 8'd3}, '{2'd2, 8'h00, 32'd1, 8'd3},
        '{2'd1, 8'h30, 32'd0, 8'd4}, '{2'd2, 8'h00, 32'd1, 8'd4},
        '{2'd1, 8'h24, 32'd0, 8'd4}, '{2'd1, 8'h30, 32'd1, 8'd4},
        '{2'd3, 8'h00, 32'd1, 8'd6}, '{2'd0, 8'h50, 32'd1, 8'd7},
        '{2'd3, 8'h00, 32'd3, 8'd7}, '{2'd2, 8'h00, 32'd2, 8'd4},
        '{2'd1, 8'h24, 32'd0, 8'd4}, '{2'd0, 8'h30, 32'd0, 8'd5},
        '{2'd1, 8'h30, 32'd1, 8'd5}, '{2'd0, 8'h30, 32'd1, 8'd5},
        '{2'd1, 8'h30, 32'd0, 8'd5}, '{2'd3, 8'h00, 32'd0, 8'd6},
        '{2'd2, 8'h00, 32'd3, 8'd4}, '{2'd1, 8'h30, 32'd0, 8'd4}
    };

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: addr %h got %0d expected %0d", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic outs(input logic [1:0] exp, input string tag);
        #1;
        n_chk++;
        if ({alarm_wake, alarm_irq} !== exp) begin
            n_bad++;
            $display("FAIL %s: {wake,irq} got %b expected %b", tag, {alarm_wake, alarm_irq}, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h20, 0, "R1 load"); rd(8'h24, 0, "R1 live"); rd(8'h28, 0, "R1 cen");
        rd(8'h2C, 0, "R1 ien"); rd(8'h30, 0, "R1 pend"); rd(8'h50, 0, "R1 wake");
        outs(2'b00, "R1 outputs");

        // table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
            case (VECS[k].op)
                2'd0: wr(VECS[k].addr, VECS[k].data);
                2'd1: rd(VECS[k].addr, VECS[k].data, tag);
                2'd2: ticks(int'(VECS[k].data));
                default: outs(VECS[k].data[1:0], tag);
            endcase
        end

        // R3 disabled counter holds
        wr(8'h28, 0); wr(8'h20, 5); ticks(3);
        rd(8'h24, 5, "R3 hold while disabled");
        // R8 load zero never pends
        wr(8'h28, 1); wr(8'h20, 0); ticks(3);
        rd(8'h30, 0, "R8 zero load");
        // R8 reload mid-count restarts
        wr(8'h20, 4); ticks(1); wr(8'h20, 2); ticks(1);
        rd(8'h30, 0, "R8 restart not early"); rd(8'h24, 1, "R8 restart count");
        ticks(1);
        rd(8'h30, 1, "R8 restart expiry");
        // R6/R7 gating off while pending
        wr(8'h2C, 0); wr(8'h50, 0);
        outs(2'b00, "R6 R7 gated off");
        wr(8'h50, 1);
        outs(2'b10, "R7 wake only");
        wr(8'h30, 1);
        // R5 expiry and clear in the same cycle
        wr(8'h20, 1);
        @(negedge clk);
        sec_tick = 1'b1; reg_wen = 1'b1; reg_addr = 8'h30; reg_wdata = 1;
        @(negedge clk);
        sec_tick = 1'b0; reg_wen = 1'b0;
        rd(8'h30, 1, "R5 expiry wins");
        rd(8'h24, 0, "R4 count at zero");
        // R9 weekly group
        wr(8'h44, 1); rd(8'h44, 1, "R9 weekly enable");
        wr(8'h48, 1); rd(8'h48, 1, "R9 weekly irq enable");
        rd(8'h4C, 0, "R9 weekly pending");
        wr(8'h4C, 1); rd(8'h4C, 0, "R9 weekly clear");
        // R10 ignored writes and unmapped reads
        wr(8'h24, 77); rd(8'h24, 0, "R10 live write ignored");
        rd(8'h99, 0, "R10 unmapped");
        wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, 1, "R10 upper bits zero");
        finish_run();
    end
endmodule